// File: doc/BRIEF.md
# Delayed Response Byte Sequencer

This block supplies bytes, one at a time, to a synchronous serial transmitter used by a tag-emulation front end to send its answer. Before a sequence, the response is loaded into a small internal buffer through a write port. A start pulse then captures a delay count and a response length. The block only advances when the transmitter asks for a byte. Each request gets one byte together with a one-cycle valid strobe.

The output stream has three parts. It begins with as many 0x00 bytes as the delay count. The buffered response follows in index order. It ends with a fixed trailing pad of zero bytes, and a done pulse marks the last byte. Receive traffic that shows up while a sequence runs is popped and discarded. An abort input cancels the sequence at once.

Top module: `resp_byte_seq`

## Requirements
- R1: One `tx_ready_i` cycle while `busy_o` is high produces exactly one `tx_valid_o` pulse in the next cycle. `tx_valid_o` stays low in every other cycle.
- R2: The first bytes of a sequence are 0x00. Their number equals the `delay_i` value captured at start.
- R3: After the delay bytes, buffer entries 0 to len-1 are emitted in ascending index order, one per request. The buffer holds whatever the write port last stored at each address.
- R4: The response is followed by exactly TAIL (default 5) bytes of 0x00, and then the sequence ends. The total byte count is delay+len+TAIL. With zero delay and zero length, the sequence is only the TAIL zero bytes.
- R5: `done_o` is a single-cycle pulse. It is high in the same cycle as the `tx_valid_o` of the final byte, and `busy_o` is low in that cycle.
- R6: If `abort_i` is high at an edge, no byte is emitted at that edge. In the next cycle `busy_o`, `tx_valid_o` and `done_o` are all low. An abort while idle has no effect on a later sequence.
- R7: While `busy_o` is high, `rx_read_o` follows `rx_avail_i` in the same cycle. While idle, `rx_read_o` is low.
- R8: A start pulse while a sequence is active is ignored. `delay_i` and `len_i` are sampled only at an accepted start.
- R9: After reset, and in the cycle after an accepted start, `tx_data_o` is 0x00 and `tx_valid_o` is low. After reset, `busy_o` and `done_o` are also low.
- R10: A `len_i` value larger than the buffer depth is treated as the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Buffer write enable |
| wr_addr_i | input | IDX_W | Buffer write address |
| wr_data_i | input | 8 | Buffer write data |
| start_i | input | 1 | Start a sequence (accepted when idle) |
| delay_i | input | DLY_W | Number of leading zero bytes |
| len_i | input | LEN_W | Response length in bytes |
| abort_i | input | 1 | Cancel the sequence immediately |
| tx_ready_i | input | 1 | Transmitter requests a byte |
| tx_data_o | output | 8 | Byte presented to the transmitter |
| tx_valid_o | output | 1 | `tx_data_o` carries a new byte this cycle |
| rx_avail_i | input | 1 | Receive byte available |
| rx_read_o | output | 1 | Pop (discard) the receive byte |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Final byte presented this cycle |

## Verification
Every byte is due exactly one cycle after the edge that samples its request. The bench raises `tx_ready_i` for one cycle, drops it, and checks `tx_valid_o`, `tx_data_o`, `done_o` and `busy_o` at the next falling edge. The effect of an abort is checked at that same falling edge. `rx_read_o` has no register in its path, so it is checked a moment after `rx_avail_i` changes, within the same cycle. Between requests the bench inserts idle gaps of random length and confirms that no strobe appears in them.

// File: rtl/resp_seq_pkg.sv
package resp_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_DELAY   = 2'd1,
    ST_PAYLOAD = 2'd2,
    ST_DONE    = 2'd3
  } seq_state_e;
endpackage

// File: rtl/resp_seq_buf.sv
module resp_seq_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [DW-1:0]    rd_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i && (int'(wr_addr_i) < DEPTH)) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = (int'(rd_idx_i) < DEPTH) ? mem_q[rd_idx_i] : '0;
endmodule

// File: rtl/resp_seq_ctrl.sv
module resp_seq_ctrl
  import resp_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DLY_W = 8,
  parameter int TAIL  = 5,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1),
  localparam int CNT_W = $clog2(DEPTH + TAIL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             abort_i,
  input  logic             tx_ready_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             emit_o,
  output logic             sel_buf_o,
  output logic             preload_o,
  output logic [IDX_W-1:0] rd_idx_o
);
  seq_state_e       state_q;
  logic [DLY_W-1:0] dly_q;
  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] idx_q;
  logic [LEN_W-1:0] len_clamped;
  logic [CNT_W-1:0] last_idx;

  assign busy_o      = (state_q == ST_DELAY) || (state_q == ST_PAYLOAD);
  assign done_o      = (state_q == ST_DONE);
  assign emit_o      = busy_o && tx_ready_i && !abort_i;
  assign preload_o   = (state_q == ST_IDLE) && start_i && !abort_i;
  assign len_clamped = (int'(len_i) > DEPTH) ? LEN_W'(DEPTH) : len_i;
  assign last_idx    = CNT_W'(len_q) + CNT_W'(TAIL - 1);
  assign sel_buf_o   = (state_q == ST_PAYLOAD) && (idx_q < CNT_W'(len_q));
  assign rd_idx_o    = idx_q[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dly_q   <= '0;
      len_q   <= '0;
      idx_q   <= '0;
    end else if (abort_i) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          dly_q   <= delay_i;
          len_q   <= len_clamped;
          idx_q   <= '0;
          state_q <= (delay_i == '0) ? ST_PAYLOAD : ST_DELAY;
        end
        ST_DELAY: if (tx_ready_i) begin
          dly_q <= dly_q - DLY_W'(1);
          if (dly_q == DLY_W'(1)) state_q <= ST_PAYLOAD;
        end
        ST_PAYLOAD: if (tx_ready_i) begin
          idx_q <= idx_q + CNT_W'(1);
          if (idx_q == last_idx) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_idx_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAYLOAD) |-> (idx_q <= last_idx));
  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_delay_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DELAY) |-> (dly_q != '0));
endmodule

// File: rtl/resp_seq_out.sv
module resp_seq_out #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          preload_i,
  input  logic          emit_i,
  input  logic [DW-1:0] byte_i,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_data_o  <= '0;
      tx_valid_o <= 1'b0;
    end else begin
      tx_valid_o <= emit_i;
      if (preload_i)   tx_data_o <= '0;
      else if (emit_i) tx_data_o <= byte_i;
    end
  end
endmodule

// File: rtl/resp_byte_seq.sv
module resp_byte_seq #(
  parameter int DEPTH = 16,
  parameter int DLY_W = 8,
  parameter int TAIL  = 5,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic             start_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             abort_i,
  input  logic             tx_ready_i,
  output logic [7:0]       tx_data_o,
  output logic             tx_valid_o,
  input  logic             rx_avail_i,
  output logic             rx_read_o,
  output logic             busy_o,
  output logic             done_o
);
  logic             emit, sel_buf, preload;
  logic [IDX_W-1:0] rd_idx;
  logic [7:0]       rd_data, next_byte;

  resp_seq_buf #(.DEPTH(DEPTH), .DW(8)) u_buf (
    .clk_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

  resp_seq_ctrl #(.DEPTH(DEPTH), .DLY_W(DLY_W), .TAIL(TAIL)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .delay_i, .len_i, .abort_i, .tx_ready_i,
    .busy_o, .done_o, .emit_o(emit), .sel_buf_o(sel_buf),
    .preload_o(preload), .rd_idx_o(rd_idx)
  );

  assign next_byte = sel_buf ? rd_data : 8'h00;

  resp_seq_out #(.DW(8)) u_out (
    .clk_i, .rst_ni, .preload_i(preload), .emit_i(emit), .byte_i(next_byte),
    .tx_data_o, .tx_valid_o
  );

  // received bytes are drained while a sequence runs
  assign rx_read_o = rx_avail_i && busy_o;

  assert_valid_after_ready_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(tx_ready_i));
  assert_valid_only_active_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (busy_o || done_o));
  assert_abort_stops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_o && !tx_valid_o && !done_o));
  assert_done_not_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && tx_valid_o));
endmodule

// File: tb/resp_byte_seq_test.sv
module resp_byte_seq_test;
  localparam int DEPTH = 16;
  localparam int DLY_W = 8;
  localparam int TAIL  = 5;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int LEN_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [IDX_W-1:0] wr_addr = '0;
  logic [7:0]       wr_data = '0;
  logic             start = 1'b0;
  logic [DLY_W-1:0] delay = '0;
  logic [LEN_W-1:0] len = '0;
  logic             abort = 1'b0;
  logic             tx_ready = 1'b0;
  logic [7:0]       tx_data;
  logic             tx_valid;
  logic             rx_avail = 1'b0;
  logic             rx_read;
  logic             busy;
  logic             done;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic [7:0] model_mem [DEPTH];

  always #10 clk = ~clk;

  resp_byte_seq #(.DEPTH(DEPTH), .DLY_W(DLY_W), .TAIL(TAIL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .start_i(start), .delay_i(delay), .len_i(len),
    .abort_i(abort), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .tx_valid_o(tx_valid), .rx_avail_i(rx_avail), .rx_read_o(rx_read),
    .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int clamp_len(input int l);
    return (l > DEPTH) ? DEPTH : l;
  endfunction

  function automatic logic [7:0] exp_byte(input int k, input int d, input int l);
    if (k < d) return 8'h00;
    if (k - d < l) return model_mem[k - d];
    return 8'h00;
  endfunction

  task automatic write_buf(input int a, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = IDX_W'(a); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    model_mem[a] = v;
  endtask

  task automatic start_seq(input int d, input int l);
    @(negedge clk);
    start = 1'b1; delay = DLY_W'(d); len = LEN_W'(l);
    @(negedge clk);
    start = 1'b0;
    delay = DLY_W'($urandom); len = LEN_W'($urandom);
    chk(busy == 1'b1, "R8 busy after start", busy, 1);
    chk(tx_data == 8'h00 && tx_valid == 1'b0, "R9 preload zero", tx_data, 0);
  endtask

  // one request; returns observed byte; bench checks it
  task automatic request(input bit try_start, output logic [7:0] got,
                         output logic v, output logic dn, output logic bz);
    int gap = $urandom_range(0, 3);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk(tx_valid == 1'b0, "R1 no strobe in gap", tx_valid, 0);
    end
    @(negedge clk);
    tx_ready = 1'b1;
    rx_avail = 1'($urandom);
    if (try_start) begin
      start = 1'b1; delay = DLY_W'($urandom); len = LEN_W'($urandom);
    end
    #1;
    chk(rx_read == rx_avail, "R7 rx drained while busy", rx_read, rx_avail);
    @(negedge clk);
    tx_ready = 1'b0; start = 1'b0; rx_avail = 1'b0;
    got = tx_data; v = tx_valid; dn = done; bz = busy;
  endtask

  task automatic run_seq(input int d, input int l_in, input int abort_at);
    int l = clamp_len(l_in);
    int total = d + l + TAIL;
    logic [7:0] got;
    logic v, dn, bz;
    start_seq(d, l_in);
    for (int k = 0; k < total; k++) begin
      if (k == abort_at) begin
        @(negedge clk);
        abort = 1'b1; tx_ready = 1'b1;
        @(negedge clk);
        abort = 1'b0; tx_ready = 1'b0;
        chk(!tx_valid && !busy && !done, "R6 abort stops", {tx_valid, busy, done}, 0);
        @(negedge clk);
        chk(!tx_valid && !done, "R6 nothing after abort", {tx_valid, done}, 0);
        return;
      end
      request(($urandom_range(0, 3) == 0), got, v, dn, bz);
      chk(v == 1'b1, "R1 strobe per request", v, 1);
      if (k < d)
        chk(got == 8'h00, "R2 leading zero", got, 0);
      else if (k < d + l)
        chk(got == exp_byte(k, d, l), "R3 payload byte", got, exp_byte(k, d, l));
      else
        chk(got == 8'h00, "R4 trailing zero", got, 0);
      if (k == total - 1)
        chk(dn == 1'b1 && bz == 1'b0, "R5 done with last byte", {dn, bz}, 2'b10);
      else
        chk(dn == 1'b0 && bz == 1'b1, "R4 still running", {dn, bz}, 2'b01);
    end
    @(negedge clk);
    chk(!done && !busy && !tx_valid, "R5 done single cycle", {done, busy, tx_valid}, 0);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    chk(!tx_valid, "R1 no byte when idle", tx_valid, 0);
    rx_avail = 1'b1;
    #1;
    chk(rx_read == 1'b0, "R7 no read when idle", rx_read, 0);
    rx_avail = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !tx_valid && tx_data == 8'h00, "R9 reset state",
        {busy, done, tx_valid, tx_data}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) write_buf(i, 8'($urandom));
    write_buf(0, 8'hA5);
    // directed corners
    run_seq(0, 0, -1);            // R4 only tail
    run_seq(3, 0, -1);
    run_seq(0, DEPTH, -1);
    run_seq(2, 20, -1);           // R10 clamp
    run_seq(4, 6, 2);             // R6 abort in delay
    run_seq(1, 8, 5);             // R6 abort in payload
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    run_seq(2, 3, -1);            // R6 idle abort harmless
    // random
    for (int n = 0; n < 25; n++) begin
      if ($urandom_range(0, 1) == 1) write_buf($urandom_range(0, DEPTH - 1), 8'($urandom));
      run_seq($urandom_range(0, 6), $urandom_range(0, 20),
              ($urandom_range(0, 7) == 0) ? $urandom_range(0, 6) : -1);
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule